// File: doc/BRIEF.md
# CPU Instruction Timing State Sequencer

This block produces the per-cycle timing code for a small 8-bit processor. Each cycle it presents a set of explicit timing lines: a final-cycle line (T0), a fetch line (T+) and one line per execution step (T2 and onward). Together with the opcode held in the instruction register, these lines select the decode terms for that cycle. The code is not one-hot. Two states drive a pair of lines at once. Two states drive none and differ only by an internal blanking indicator. That indicator is high for the "fresh fetch" state T1 and low for the "overflow" state T6.

The decode logic steers the sequencer with five strobes: a last-cycle request, a two-cycle-instruction mark, branch-not-taken, branch-taken-same-page and branch-page-crossed. The way an instruction ends decides the next fetch state. Ending through T0 gives a T+ fetch. Ending in a bare step state, as untaken or short branches do, gives a T1 fetch. A reset request aborts into T0 and then parks in T0+T+. The number of step lines and the output polarity are parameters. The defaults are four steps (T2..T5) and active-low outputs.

Top module: `cyc_phase_seq`

## Requirements
- R1: Output `tcode` places T0 at bit 0, T+ at bit 1 and step Tk at bit k for k = 2..STEPS+1. With ACTIVE_LOW=1 a line is active when it reads 0.
- R2: With `rst_n` low, the next state is T0+T+ if the current state includes T0, and T0 alone otherwise. Holding `rst_n` low keeps the sequencer in T0+T+.
- R3: When `rst_n` is high in T0+T+, the next state is T2 alone, whatever the strobes are.
- R4: From T0 or T0+T2, the next state is T+ alone, and all strobes are ignored.
- R5: From a fetch state (T+ or T1), the next state is T0+T2 when `two_cyc` is high and T2 alone otherwise.
- R6: With no strobe, the step states advance T2, T3, ... up to the last step, then T6, then T0. In T6 no line is active and `blank_clr` is low.
- R7: In any step state, `last_cyc` or `br_far` makes the next state T0. This takes priority over the branch strobes.
- R8: In T2, `br_skip` makes the next state T1: no line active and `blank_clr` high. In every other state `br_skip` has no effect.
- R9: In T3, `br_near` makes the next state T1. In every other state `br_near` has no effect.
- R10: `fetch_cyc` is high exactly in T+, T1 and T0+T+.
- R11: At most two lines are active at once. Any active pair is T0+T+ or T0+T2. At most one step line is active. `blank_clr` is high only when no line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset request, active low, sampled each edge |
| last_cyc | input | 1 | Decode asks for the final cycle next |
| two_cyc | input | 1 | Instruction being fetched is strictly two-cycle |
| br_skip | input | 1 | Conditional branch not taken |
| br_near | input | 1 | Branch taken, target on the same page |
| br_far | input | 1 | Branch taken, target on another page |
| tcode | output | STEPS+2 | Explicit timing lines (T0, T+, T2..) |
| fetch_cyc | output | 1 | Current cycle is an opcode fetch |
| blank_clr | output | 1 | Blanking indicator, high in T1 only |

## Verification
The assertions assume only one thing about the inputs: `rst_n` is held low for at least two edges before its first release. That drives any power-up contents into T0+T+. After that, every check is disabled while reset is low. The strobes carry no assumption. The design gives any combination of them a defined priority, so the stimulus asserts them freely and in overlapping patterns, including strobes in states where they must be ignored. The stimulus opens with the long reset, then runs directed sequences and a pseudo-random sweep with occasional mid-instruction resets.

// File: rtl/cyc_phase_pkg.sv
package cyc_phase_pkg;

   // Fixed positions inside the state vector and the tcode output.
   localparam int unsigned T0_BIT   = 0;
   localparam int unsigned TP_BIT   = 1;
   localparam int unsigned STEP_LSB = 2;

   // Kind of transition chosen for the coming edge.
   typedef enum logic [3:0] {
      RT_ABORT_T0,   // reset seen outside T0: go to T0
      RT_ABORT_PAIR, // reset seen in a T0 state: go to T0+T+
      RT_FETCH_P,    // after a T0 cycle: T+ fetch
      RT_FETCH_1,    // after a bare-step final cycle: T1 fetch
      RT_FINAL,      // enter T0 alone
      RT_PAIR2,      // two-cycle instruction: T0+T2
      RT_FIRST,      // first execution step T2
      RT_SHIFT       // advance to the next step (last one falls into T6)
   } route_e;

endpackage

// File: rtl/cyc_phase_route.sv
module cyc_phase_route
   import cyc_phase_pkg::*;
#(
   parameter int unsigned STEPS = 4,
   localparam int unsigned SW   = STEPS + 3
)(
   input  logic [SW-1:0] st_i,
   input  logic          rst_n,
   input  logic          last_cyc,
   input  logic          two_cyc,
   input  logic          br_skip,
   input  logic          br_near,
   input  logic          br_far,
   output route_e        route_o
);

   localparam int unsigned CLR_BIT = STEPS + 2;

   logic             has_t0;
   logic             has_tp;
   logic             has_clr;
   logic [STEPS-1:0] steps;
   logic             in_fetch;
   logic             in_t6;
   logic             end_req;
   logic             short_br;

   assign has_t0   = st_i[T0_BIT];
   assign has_tp   = st_i[TP_BIT];
   assign has_clr  = st_i[CLR_BIT];
   assign steps    = st_i[STEP_LSB +: STEPS];
   assign in_fetch = has_tp | has_clr;
   assign in_t6    = ~has_t0 & ~in_fetch & ~(|steps);
   assign end_req  = last_cyc | br_far;
   // Branch-end strobes are qualified by the step they belong to.
   assign short_br = (br_skip & steps[0]) | (br_near & steps[1]);

   always_comb begin
      if (!rst_n) begin
         route_o = has_t0 ? RT_ABORT_PAIR : RT_ABORT_T0;
      end else if (has_t0 && has_tp) begin
         route_o = RT_FIRST;
      end else if (has_t0) begin
         route_o = RT_FETCH_P;
      end else if (in_fetch) begin
         route_o = two_cyc ? RT_PAIR2 : RT_FIRST;
      end else if (in_t6) begin
         route_o = RT_FINAL;
      end else if (end_req) begin
         route_o = RT_FINAL;
      end else if (short_br) begin
         route_o = RT_FETCH_1;
      end else begin
         route_o = RT_SHIFT;
      end
   end

endmodule

// File: rtl/cyc_phase_build.sv
module cyc_phase_build
   import cyc_phase_pkg::*;
#(
   parameter int unsigned STEPS = 4,
   localparam int unsigned SW   = STEPS + 3
)(
   input  route_e        route_i,
   input  logic [SW-1:0] st_i,
   output logic [SW-1:0] nxt_o
);

   localparam int unsigned CLR_BIT = STEPS + 2;

   logic [STEPS-1:0] shifted;

   // The top step drops out, leaving an all-clear T6 vector.
   assign shifted = {st_i[STEP_LSB +: STEPS-1], 1'b0};

   always_comb begin
      nxt_o = '0;
      unique case (route_i)
         RT_ABORT_T0:   nxt_o[T0_BIT] = 1'b1;
         RT_ABORT_PAIR: begin
            nxt_o[T0_BIT] = 1'b1;
            nxt_o[TP_BIT] = 1'b1;
         end
         RT_FETCH_P:    nxt_o[TP_BIT] = 1'b1;
         RT_FETCH_1:    nxt_o[CLR_BIT] = 1'b1;
         RT_FINAL:      nxt_o[T0_BIT] = 1'b1;
         RT_PAIR2: begin
            nxt_o[T0_BIT]   = 1'b1;
            nxt_o[STEP_LSB] = 1'b1;
         end
         RT_FIRST:      nxt_o[STEP_LSB] = 1'b1;
         RT_SHIFT:      nxt_o[STEP_LSB +: STEPS] = shifted;
         default:       nxt_o = '0;
      endcase
   end

endmodule

// File: rtl/cyc_phase_reg.sv
module cyc_phase_reg #(
   parameter int unsigned WIDTH = 7
)(
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   // Reset is functional and arrives through the routing logic.
   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/cyc_phase_drive.sv
module cyc_phase_drive
   import cyc_phase_pkg::*;
#(
   parameter int unsigned STEPS      = 4,
   parameter bit          ACTIVE_LOW = 1'b1,
   localparam int unsigned SW        = STEPS + 3,
   localparam int unsigned OW        = STEPS + 2
)(
   input  logic [SW-1:0] st_i,
   output logic [OW-1:0] tcode,
   output logic          fetch_cyc,
   output logic          blank_clr
);

   localparam int unsigned CLR_BIT = STEPS + 2;

   logic [OW-1:0] lines;

   assign lines     = st_i[OW-1:0];
   assign blank_clr = st_i[CLR_BIT];
   assign fetch_cyc = st_i[TP_BIT] | st_i[CLR_BIT];

   generate
      if (ACTIVE_LOW) begin : g_low
         assign tcode = ~lines;
      end else begin : g_high
         assign tcode = lines;
      end
   endgenerate

endmodule

// File: rtl/cyc_phase_seq.sv
module cyc_phase_seq
   import cyc_phase_pkg::*;
#(
   parameter int unsigned STEPS      = 4,
   parameter bit          ACTIVE_LOW = 1'b1,
   localparam int unsigned SW        = STEPS + 3,
   localparam int unsigned OW        = STEPS + 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          last_cyc,
   input  logic          two_cyc,
   input  logic          br_skip,
   input  logic          br_near,
   input  logic          br_far,
   output logic [OW-1:0] tcode,
   output logic          fetch_cyc,
   output logic          blank_clr
);

   generate
      if (STEPS < 2 || STEPS > 12) begin : g_bad_steps
         $error("cyc_phase_seq: STEPS must be within 2..12");
      end
   endgenerate

   logic [SW-1:0] st_q;
   logic [SW-1:0] st_d;
   route_e        route;

   cyc_phase_route #(.STEPS(STEPS)) u_route (
      .st_i     (st_q),
      .rst_n    (rst_n),
      .last_cyc (last_cyc),
      .two_cyc  (two_cyc),
      .br_skip  (br_skip),
      .br_near  (br_near),
      .br_far   (br_far),
      .route_o  (route)
   );

   cyc_phase_build #(.STEPS(STEPS)) u_build (
      .route_i (route),
      .st_i    (st_q),
      .nxt_o   (st_d)
   );

   cyc_phase_reg #(.WIDTH(SW)) u_reg (
      .clk (clk),
      .d   (st_d),
      .q   (st_q)
   );

   cyc_phase_drive #(.STEPS(STEPS), .ACTIVE_LOW(ACTIVE_LOW)) u_drive (
      .st_i      (st_q),
      .tcode     (tcode),
      .fetch_cyc (fetch_cyc),
      .blank_clr (blank_clr)
   );

endmodule

// File: rtl/cyc_phase_chk.sv
module cyc_phase_chk #(
   parameter int unsigned STEPS      = 4,
   parameter bit          ACTIVE_LOW = 1'b1,
   localparam int unsigned OW        = STEPS + 2
)(
   input logic          clk,
   input logic          rst_n,
   input logic [OW-1:0] tcode,
   input logic          fetch_cyc,
   input logic          blank_clr
);

   logic [OW-1:0] act;
   assign act = ACTIVE_LOW ? ~tcode : tcode;

   a_r11_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(act) == 2) |-> (act[0] && (act[1] || act[2])));

   a_r11_count_max: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act) <= 2);

   a_r11_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act[OW-1:2]));

   a_r11_blank_empty: assert property (@(posedge clk) disable iff (!rst_n)
      blank_clr |-> (act == '0));

   a_r4_final_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (act[0] && !act[1]) |=> (act[1] && $countones(act) == 1));

   a_r3_release_first: assert property (@(posedge clk) disable iff (!rst_n)
      (act[0] && act[1]) |=> (act[2] && !act[1]));

   a_r5_fetch_then_step: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_cyc |=> act[2]);

   a_r6_overflow_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0 && !blank_clr) |=> (act[0] && $countones(act) == 1));

endmodule

bind cyc_phase_seq cyc_phase_chk #(.STEPS(STEPS), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tcode     (tcode),
   .fetch_cyc (fetch_cyc),
   .blank_clr (blank_clr)
);

// File: tb/cyc_phase_seq_bench.sv
module cyc_phase_seq_bench;

   // Model state ids
   localparam int S_T0 = 0, S_TP = 1, S_T6 = 6, S_T1 = 7, S_PAIRP = 8, S_PAIR2 = 9;
   // ids 2..5 are steps T2..T5

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       last_cyc = 1'b0, two_cyc = 1'b0, br_skip = 1'b0, br_near = 1'b0, br_far = 1'b0;
   logic [5:0] tcode;
   logic       fetch_cyc, blank_clr;

   int checks = 0;
   int fails  = 0;
   int model  = S_PAIRP;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cyc_phase_seq u_cyc_phase_seq (
      .clk(clk), .rst_n(rst_n), .last_cyc(last_cyc), .two_cyc(two_cyc),
      .br_skip(br_skip), .br_near(br_near), .br_far(br_far),
      .tcode(tcode), .fetch_cyc(fetch_cyc), .blank_clr(blank_clr)
   );

   function automatic logic [5:0] lines_of(int id);
      case (id)
         S_T0:    return 6'b000001;
         S_TP:    return 6'b000010;
         S_PAIRP: return 6'b000011;
         S_PAIR2: return 6'b000101;
         S_T6, S_T1: return 6'b000000;
         default: return 6'(1 << id);
      endcase
   endfunction

   function automatic int next_of(int id, logic rs, logic la, logic tw,
                                  logic sk, logic nr, logic fr);
      if (!rs) return (id == S_T0 || id == S_PAIRP || id == S_PAIR2) ? S_PAIRP : S_T0;
      if (id == S_PAIRP) return 2;
      if (id == S_T0 || id == S_PAIR2) return S_TP;
      if (id == S_TP || id == S_T1) return tw ? S_PAIR2 : 2;
      if (id == S_T6) return S_T0;
      if (la || fr) return S_T0;
      if (sk && id == 2) return S_T1;
      if (nr && id == 3) return S_T1;
      return (id == 5) ? S_T6 : id + 1;
   endfunction

   task automatic check_all(string req);
      logic [5:0] exp_t;
      logic       exp_f, exp_b;
      exp_t = ~lines_of(model);
      exp_f = (model == S_TP || model == S_T1 || model == S_PAIRP);
      exp_b = (model == S_T1);
      checks++;
      if (tcode !== exp_t || fetch_cyc !== exp_f || blank_clr !== exp_b) begin
         fails++;
         $display("FAIL %s: tcode=%b fetch=%b blank=%b expected tcode=%b fetch=%b blank=%b",
                  req, tcode, fetch_cyc, blank_clr, exp_t, exp_f, exp_b);
      end
   endtask

   // Called at a falling edge: drive, clock, step the model, check at the next falling edge.
   task automatic cyc(logic rs, logic la, logic tw, logic sk, logic nr, logic fr, string req);
      rst_n = rs; last_cyc = la; two_cyc = tw; br_skip = sk; br_near = nr; br_far = fr;
      @(posedge clk);
      model = next_of(model, rs, la, tw, sk, nr, fr);
      @(negedge clk);
      check_all(req);
   endtask

   task automatic idle(string req);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
   endtask

   initial begin
      logic [15:0] lfsr;
      @(negedge clk);
      // Two reset edges force any content into T0+T+
      rst_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      model = S_PAIRP;
      check_all("R2 reset state T0+T+ and R1 bit positions");
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R2 held reset stays T0+T+");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 release goes to T2 despite two_cyc");
      // Long instruction: T3 T4 T5 T6 T0 T+
      idle("R6 T3");
      idle("R6 T4");
      idle("R6 T5");
      idle("R6 T6 blank low");
      idle("R6 T6 to T0");
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 T0 to T+ ignoring strobes R10");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 two-cycle T0+T2");
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 T0+T2 to T+");
      idle("R5 plain fetch to T2");
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 branch skip to T1");
      idle("R5 T1 fetch to T2");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 br_near ignored in T2");
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 br_skip ignored in T3");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 br_near ignored in T4");
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 last_cyc from T5");
      idle("R4 T+");
      idle("R5 T2");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 T3");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 br_near in T3 to T1");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 T1 with two_cyc to T0+T2");
      idle("R4 to T+");
      idle("R5 T2");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 br_far from T2 to T0");
      idle("R4 T+");
      idle("R5 T2");
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 last beats br_skip");
      idle("R4 T+");
      idle("R5 T2");
      idle("R6 T3");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 abort to T0");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 T0 under reset to T0+T+");
      idle("R3 release to T2");
      // Pseudo-random sweep with model comparison
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         logic rs;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rs = !(lfsr[4:0] == 5'd0);
         cyc(rs, lfsr[7:5] == 3'd0, lfsr[8], lfsr[9], lfsr[10], lfsr[13:11] == 3'd0,
             "R11 sweep");
         if (lines_of(model) != 6'd0) begin
            checks++;
            if ($countones(~tcode) > 2) begin
               fails++;
               $display("FAIL R11: tcode=%b has more than two active, expected at most two", tcode);
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule